// File: doc/BRIEF.md
# Timed Register-Write Sequencer

This block turns a stream of 32-bit command words into paced writes on a small sound-chip register bus. Each command holds a wait count, an address, a data byte and a few spare bits. The wait count gives the spacing the command asks for between the previous write strobe and its own. When that spacing is reached, the block drives the address, the data and a chip-select for one cycle, together with a write strobe. Each write is followed by a fixed recovery gap in which no new command is taken.

Commands enter through a valid/ready handshake. `cmd_ready` is high only while the block is idle. A command is taken at a rising edge where both `cmd_valid` and `cmd_ready` are high. While `cmd_ready` is low the source must hold its word and its valid; nothing is consumed. Only one command is in flight at a time, so back-pressure lasts from the acceptance until the recovery of that command ends.

The hardware enforces a minimum write-to-write spacing of RECOV+2 cycles. A command can ask for less than that. The cycles it loses are then kept in a lag count, and the block takes them back out of later requests that are long enough. This keeps the average timing of the stream on schedule. A command whose only purpose is to wait is written as an ordinary write to an unused register, for example 0x19.

Top module: `regwrite_sequencer`

## Requirements
- R1: Command word fields are: bits 31:16 the requested spacing D, bits 15:13 spare, bits 12:8 the register address, bits 7:0 the data. Every accepted command produces exactly one write carrying its address and data. This includes writes to an unused address such as 0x19, which are used as wait-only commands.
- R2: `cmd_ready` is high exactly when the block is idle. A command is taken at a rising edge with `cmd_valid` and `cmd_ready` both high, and `cmd_ready` is low in the cycle after that edge.
- R3: `wr_strobe` is high for exactly one cycle per write and never for two cycles in a row.
- R4: Let the target T be computed as in R6. A write occurs in the first cycle that is both (a) no earlier than one cycle after acceptance and (b) at least T cycles after the previous write cycle. After reset the previous write counts as long ago, so the first command's write occurs one cycle after it is accepted.
- R5: After each write, `cmd_ready` stays low for RECOV (default 4) further cycles. Two writes are never closer than RECOV+2 (default 6) cycles.
- R6: On acceptance the target is T = D − L if D ≥ L, and T = 0 otherwise. L is the lag count. The lag is then updated to L' = max(0, L + RECOV + 2 − D), capped at 65535. The lag is 0 after reset.
- R7: `chip_sel` is one-hot during the write cycle. The set bit is given by the low log2(NCHIP) spare bits (bit 13 upward). The other spare bits have no effect. `chip_sel` is all zero in every other cycle.
- R8: `reg_addr` and `reg_data` are zero in every cycle without a write strobe.
- R9: During and right after reset, `cmd_ready` is 1 and `wr_strobe`, `chip_sel`, `reg_addr` and `reg_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word is offered |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_word | input | 32 | Command word (spacing, spare, address, data) |
| chip_sel | output | NCHIP | One-hot chip-select, high during the write cycle |
| reg_addr | output | 5 | Register address during the write cycle |
| reg_data | output | 8 | Data byte during the write cycle |
| wr_strobe | output | 1 | One-cycle write strobe |

## Verification
Two things can happen in the same cycle: accepting a command and deciding that its write is already due. When the spacing target has been met by the time the block goes idle, the write follows one cycle after acceptance, with no wait state. This case is provoked in two ways: by back-to-back zero-spacing commands and by a request of exactly six cycles, and both land on the recovery boundary. Lag absorption falls in the same acceptance cycle. It is exercised by a burst that builds up lag and is then followed by a long request, and by a burst that drives the lag to saturation. A behavioural model in the bench predicts every strobe cycle and every ready level, and the outputs are compared with it on each clock.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int DLY_W  = 16;
  localparam int RSV_W  = 3;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int CMD_W  = DLY_W + RSV_W + ADDR_W + DATA_W;

  typedef struct packed {
    logic [DLY_W-1:0]  dly;
    logic [RSV_W-1:0]  spare;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RECOV = 2'd3
  } seq_state_t;
endpackage

// File: rtl/seq_lag_calc.sv
module seq_lag_calc #(
  parameter int DLY_W   = 16,
  parameter int MIN_GAP = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [DLY_W-1:0] req_dly,
  output logic [DLY_W-1:0] target,
  output logic [DLY_W-1:0] lag_q
);
  localparam int EXT_W = DLY_W + 2;
  localparam logic [EXT_W-1:0] CAP = EXT_W'({DLY_W{1'b1}});

  logic [EXT_W-1:0] owed, req_ext, diff;
  logic [DLY_W-1:0] lag_d;

  // take the lag back out of the request when the request can absorb it
  assign target = (req_dly >= lag_q) ? (req_dly - lag_q) : '0;

  always_comb begin
    owed    = EXT_W'(lag_q) + EXT_W'(MIN_GAP);
    req_ext = EXT_W'(req_dly);
    diff    = owed - req_ext;
    if (owed <= req_ext)  lag_d = '0;
    else if (diff > CAP)  lag_d = '1;
    else                  lag_d = diff[DLY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lag_q <= '0;
    else if (commit) lag_q <= lag_d;
  end

  // R6: a request covering lag plus minimum spacing clears the lag
  a_r6_lag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (EXT_W'(req_dly) >= EXT_W'(lag_q) + EXT_W'(MIN_GAP))) |=> (lag_q == '0));
endmodule

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] target,
  output logic         due,
  output logic [W-1:0] since_q
);
  // cycles since the last write; saturates so an old write counts as long ago
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_q <= '1;
    else if (restart)        since_q <= '0;
    else if (since_q != '1)  since_q <= since_q + 1'b1;
  end

  // the next cycle meets the spacing target
  assign due = ((W+1)'(since_q) + (W+1)'(1)) >= (W+1)'(target);
endmodule

// File: rtl/seq_chip_decode.sv
module seq_chip_decode #(
  parameter int NCHIP  = 4,
  parameter int IDX_W  = 2
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             en,
  output logic [NCHIP-1:0] cs
);
  generate
    if (NCHIP == 1) begin : g_single
      logic unused_idx;
      assign unused_idx = ^idx;
      assign cs = en;
    end else begin : g_multi
      for (genvar i = 0; i < NCHIP; i++) begin : g_cs
        assign cs[i] = en && (idx == IDX_W'(i));
      end
    end
  endgenerate
endmodule

// File: rtl/regwrite_sequencer.sv
module regwrite_sequencer #(
  parameter int NCHIP = 4,
  parameter int RECOV = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [seq_pkg::CMD_W-1:0]    cmd_word,
  output logic [NCHIP-1:0]             chip_sel,
  output logic [seq_pkg::ADDR_W-1:0]   reg_addr,
  output logic [seq_pkg::DATA_W-1:0]   reg_data,
  output logic                         wr_strobe
);
  import seq_pkg::*;

  localparam int MIN_GAP = RECOV + 2;
  localparam int CNT_W   = (RECOV > 1) ? $clog2(RECOV) : 1;
  localparam int IDX_W   = (NCHIP > 1) ? $clog2(NCHIP) : 1;
  localparam int CHK_W   = $clog2(MIN_GAP) + 1;

  cmd_t             in_cmd;
  seq_state_t       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DLY_W-1:0]  tgt_q, tgt_now, tgt_use, lag_q, since_q;
  logic [CNT_W-1:0]  rec_q;
  logic              fire, due, go_write;
  logic              unused_spare;

  assign in_cmd       = cmd_word;
  assign unused_spare = ^in_cmd.spare;
  assign cmd_ready    = (state_q == ST_IDLE);
  assign fire         = cmd_valid && cmd_ready;
  assign tgt_use      = (state_q == ST_IDLE) ? tgt_now : tgt_q;

  seq_lag_calc #(.DLY_W(DLY_W), .MIN_GAP(MIN_GAP)) u_lag (
    .clk(clk), .rst_n(rst_n), .commit(fire), .req_dly(in_cmd.dly),
    .target(tgt_now), .lag_q(lag_q)
  );

  seq_gap_timer #(.W(DLY_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .restart(go_write), .target(tgt_use),
    .due(due), .since_q(since_q)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (fire) state_d = due ? ST_WRITE : ST_WAIT;
      ST_WAIT:  if (due)  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_RECOV;
      ST_RECOV: if (rec_q == '0) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign go_write = (state_d == ST_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rec_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      idx_q   <= '0;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (fire) begin
        addr_q <= in_cmd.addr;
        data_q <= in_cmd.data;
        idx_q  <= in_cmd.spare[IDX_W-1:0];
        tgt_q  <= tgt_now;
      end
      if (state_q == ST_WRITE)      rec_q <= CNT_W'(RECOV - 1);
      else if (state_q == ST_RECOV) rec_q <= rec_q - 1'b1;
    end
  end

  assign wr_strobe = (state_q == ST_WRITE);
  assign reg_addr  = wr_strobe ? addr_q : '0;
  assign reg_data  = wr_strobe ? data_q : '0;

  seq_chip_decode #(.NCHIP(NCHIP), .IDX_W(IDX_W)) u_cs (
    .idx(idx_q), .en(wr_strobe), .cs(chip_sel)
  );

  // checker: cycles since the last strobe, kept apart from the design state
  logic [CHK_W-1:0] chk_since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  chk_since_q <= '1;
    else if (wr_strobe)          chk_since_q <= CHK_W'(1);
    else if (chk_since_q != '1)  chk_since_q <= chk_since_q + 1'b1;
  end

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  a_r5_recovery_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (chk_since_q >= CHK_W'(RECOV + 1)));
  a_r5_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> ($past(since_q) >= DLY_W'(MIN_GAP - 1)));
  a_r7_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> ($countones(chip_sel) == 1));
  a_r7_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |-> (chip_sel == '0));
  a_r8_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |-> ((reg_addr == '0) && (reg_data == '0)));
endmodule

// File: tb/regwrite_sequencer_bench.sv
module regwrite_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCHIP      = 4;
  localparam int RECOV      = 4;
  localparam int MIN_GAP    = RECOV + 2;

  logic              clk, rst_n, cmd_valid, cmd_ready, wr_strobe;
  logic [31:0]       cmd_word;
  logic [NCHIP-1:0]  chip_sel;
  logic [4:0]        reg_addr;
  logic [7:0]        reg_data;

  regwrite_sequencer #(.NCHIP(NCHIP), .RECOV(RECOV)) u_regwrite_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .chip_sel(chip_sel), .reg_addr(reg_addr),
    .reg_data(reg_data), .wr_strobe(wr_strobe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int     n_checks = 0;
  int     n_err    = 0;
  bit     done     = 0;
  longint cyc      = 0;
  longint last_s   = -100000;
  longint strobe_at = -1;
  longint free_at  = 0;
  longint lag      = 0;
  int     e_addr, e_data, e_cs;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int d, input int spare, input int a, input int dt);
    mk = {d[15:0], spare[2:0], a[4:0], dt[7:0]};
  endfunction

  // reference: writes are spaced per target, lag per closed-form rule
  task automatic model_accept(input logic [31:0] w);
    longint d, tgt, nl, s;
    d   = w[31:16];
    tgt = (d >= lag) ? d - lag : 0;
    nl  = lag + MIN_GAP - d;
    if (nl < 0) nl = 0;
    if (nl > 65535) nl = 65535;
    lag = nl;
    s = cyc + 1;
    if (last_s + tgt > s) s = last_s + tgt;
    strobe_at = s;
    last_s    = s;
    free_at   = s + 1 + RECOV;
    e_addr    = w[12:8];
    e_data    = w[7:0];
    e_cs      = 1 << w[14:13];
  endtask

  task automatic run_cycle(input bit v, input logic [31:0] w, output bit took);
    bit er, es;
    @(negedge clk);
    cmd_valid = v;
    cmd_word  = w;
    #1;
    er = (cyc >= free_at);
    es = (cyc == strobe_at);
    check(cmd_ready == er, "R2 R5", "ready", cmd_ready, er);
    check(wr_strobe == es, "R3 R4 R6", "strobe", wr_strobe, es);
    if (es) begin
      check(reg_addr == e_addr, "R1", "addr", reg_addr, e_addr);
      check(reg_data == e_data, "R1", "data", reg_data, e_data);
      check(chip_sel == e_cs, "R7", "chip_sel", chip_sel, e_cs);
    end else begin
      check(reg_addr == 0 && reg_data == 0, "R8", "bus idle", {reg_addr, reg_data}, 0);
      check(chip_sel == 0, "R7", "chip_sel idle", chip_sel, 0);
    end
    took = v && er;
    if (took) model_accept(w);
    cyc++;
  endtask

  task automatic send(input logic [31:0] w, input int gap);
    bit t;
    for (int i = 0; i < gap; i++) run_cycle(1'b0, 32'h0, t);
    do run_cycle(1'b1, w, t); while (!t);
  endtask

  task automatic idle(input int n);
    bit t;
    for (int i = 0; i < n; i++) run_cycle(1'b0, 32'h0, t);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0;
    repeat (3) @(negedge clk);
    #1;
    check(cmd_ready == 1 && wr_strobe == 0, "R9", "reset ready/strobe", {cmd_ready, wr_strobe}, 2);
    check(chip_sel == 0 && reg_addr == 0 && reg_data == 0, "R9", "reset outputs",
          {chip_sel, reg_addr, reg_data}, 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(cmd_ready == 1 && wr_strobe == 0, "R9", "after reset", {cmd_ready, wr_strobe}, 2);

    // R4 first write right after acceptance even with a large request
    send(mk(16, 2, 5, 8'hA5), 0);
    // R5 R6 back-to-back zero requests build lag, spacing is the minimum
    send(mk(0, 1, 3, 8'h11), 0);
    send(mk(0, 0, 7, 8'h22), 0);
    send(mk(0, 3, 31, 8'h33), 0);
    // R6 long request absorbs the accumulated lag
    send(mk(40, 0, 1, 8'h44), 0);
    // exact minimum spacing: acceptance and due fall in the same cycle
    send(mk(6, 1, 2, 8'h55), 0);
    send(mk(6, 2, 4, 8'h66), 0);
    // source starvation does not add lag
    send(mk(20, 0, 9, 8'h77), 40);
    // R1 wait-only write to unused address 0x19
    send(mk(100, 0, 25, 8'h00), 0);
    send(mk(10, 0, 6, 8'h88), 0);
    // R7 spare bit 15 set has no effect on the select
    send(mk(8, 7, 10, 8'h99), 0);
    send(mk(8, 4, 11, 8'hAA), 0);
    idle(10);
    // R6 drive lag to saturation
    for (int i = 0; i < 11000; i++) send(mk(0, i % 4, i % 32, i % 256), 0);
    send(mk(16, 1, 12, 8'hBB), 0);
    send(mk(65535, 2, 13, 8'hCC), 0);
    send(mk(100, 3, 14, 8'hDD), 0);
    idle(120);
    check(lag == 0, "R6", "model lag drained", lag, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule